// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block is the receive-side holding queue of a byte-wide serial port. A deserialiser upstream offers one byte per cycle. The block takes the byte only while the receiver is switched on and the queue has room. The `ready_o` output tells the deserialiser when a byte will be taken. Software reads the queue one byte at a time. The oldest byte is always shown on `rd_data_o`, and a read strobe removes it.

Two status flags are kept alongside the queue:
- a data-ready flag, which is set while bytes are waiting;
- a full flag, which is set when all four slots hold data.

A line-break event from the deserialiser stores a zero byte in the queue and latches a sticky break flag, which software clears. If the queue is already full when a break arrives, the zero byte overwrites the most recently stored byte, so the break is never lost. A receiver-reset command switches the receiver off and discards the queue contents.

Top module: `rx_hold_queue`

## Requirements
- R1: The queue holds at most four bytes. `full_o` is 1 exactly when four bytes are held, and `count_o` never exceeds 4.
- R2: `data_rdy_o` is set by any byte stored. It clears only when a read removes the last byte.
- R3: `rd_data_o` shows the oldest held byte. Each `rd_i` cycle with a non-empty queue removes that byte, and bytes leave in arrival order.
- R4: With the queue empty, `rd_data_o` is 0x00, and a read changes neither the count nor any flag.
- R5: `break_i` stores a 0x00 byte and sets `brk_irq_o`. `brk_irq_o` stays set until `brk_clr_i`. If `break_i` and `brk_clr_i` arrive in the same cycle, the set wins.
- R6: A break with the queue full and no read in the same cycle overwrites the newest byte with 0x00. The count stays at 4, and the three older bytes are kept.
- R7: `ready_o` is 1 exactly when the receiver is enabled and `full_o` is 0. A data byte offered while `ready_o` is 0 is dropped and changes no state. A data byte offered in the same cycle as a break is also dropped.
- R8: `rx_reset_i` turns the receiver off, empties the queue, and clears `data_rdy_o` and `full_o`. It leaves `brk_irq_o` unchanged.
- R9: `rx_en_i` turns the receiver on and `rx_dis_i` turns it off. Priority is reset, then disable, then enable. Out of reset the receiver is off and the queue is empty.
- R10: A byte stored and a byte read in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable command |
| rx_dis_i | input | 1 | Receiver disable command |
| rx_reset_i | input | 1 | Receiver reset: disable and flush |
| push_valid_i | input | 1 | Deserialised byte offered |
| push_data_i | input | 8 | Offered byte |
| break_i | input | 1 | Line-break event |
| brk_clr_i | input | 1 | Clear the break flag |
| rd_i | input | 1 | Read strobe, removes the head byte |
| rd_data_o | output | 8 | Head byte, 0x00 when empty |
| ready_o | output | 1 | Queue will accept an offered byte |
| data_rdy_o | output | 1 | At least one byte held |
| full_o | output | 1 | Four bytes held |
| brk_irq_o | output | 1 | Sticky break-change flag |
| count_o | output | 3 | Number of bytes held |

## Verification
The hardest state to reach is a break arriving on a full queue with no read in the same cycle. Random stimulus seldom gets there, because reads drain the queue faster than the rare breaks arrive. A directed sequence therefore fills the queue with known bytes and then pulses `break_i`. It drains the queue and checks that only the fourth byte became zero. A second directed sequence repeats the break on a full queue together with a read, where a plain append is expected instead of an overwrite. Random traffic with a skewed mix of reads, offers, breaks and command pulses is checked every cycle against a bench queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic flush;
    logic pop;
    logic push;
    logic ovw;
    logic brk;
  } rxq_op_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             rx_dis_i,
  input  logic             rx_reset_i,
  input  logic             push_valid_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             break_i,
  input  logic             rd_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             full_i,
  output logic             ready_o,
  output rxq_pkg::rxq_op_t op_o,
  output logic [DW-1:0]    wdata_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_q <= 1'b0;
    else if (rx_reset_i) en_q <= 1'b0;
    else if (rx_dis_i)   en_q <= 1'b0;
    else if (rx_en_i)    en_q <= 1'b1;
  end

  assign ready_o = en_q & ~full_i;

  logic at_top;
  assign at_top = (cnt_i == CW'(DEPTH));

  always_comb begin
    op_o       = '0;
    op_o.flush = rx_reset_i;
    op_o.brk   = break_i;
    if (!rx_reset_i) begin
      op_o.pop = rd_i & (cnt_i != '0);
      if (break_i) begin
        // full with no read: replace newest instead of dropping
        op_o.ovw  = at_top & ~op_o.pop;
        op_o.push = ~op_o.ovw;
      end else begin
        op_o.push = push_valid_i & ready_o;
      end
    end
  end

  assign wdata_o = break_i ? '0 : push_data_i;
endmodule

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rxq_pkg::rxq_op_t op_i,
  output logic [PW-1:0]    rptr_o,
  output logic [PW-1:0]    widx_o,
  output logic [CW-1:0]    cnt_o
);
  logic [PW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign widx_o = op_i.ovw ? dec(wptr_q) : wptr_q;
  assign rptr_o = rptr_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (op_i.flush) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (op_i.pop)  rptr_q <= inc(rptr_q);
      if (op_i.push) wptr_q <= inc(wptr_q);
      case ({op_i.push, op_i.pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] rptr_i,
  input  logic [CW-1:0] cnt_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          slot_q[g] <= '0;
      else if (we_i && widx_i == PW'(g))    slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (cnt_i == '0) ? '0 : slot_q[rptr_i];
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rxq_pkg::rxq_op_t op_i,
  input  logic             brk_clr_i,
  input  logic [CW-1:0]    cnt_i,
  output logic             data_rdy_o,
  output logic             full_o,
  output logic             brk_irq_o
);
  logic rdy_q, full_q, irq_q;
  logic [CW-1:0] after_pop;

  assign after_pop = op_i.pop ? cnt_i - 1'b1 : cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (op_i.flush) begin
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (op_i.push || op_i.ovw)          rdy_q <= 1'b1;
      else if (op_i.pop && cnt_i == CW'(1)) rdy_q <= 1'b0;
      if (op_i.push && after_pop == CW'(DEPTH - 1)) full_q <= 1'b1;
      else if (op_i.pop)                            full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (op_i.brk)  irq_q <= 1'b1;
    else if (brk_clr_i) irq_q <= 1'b0;
  end

  assign data_rdy_o = rdy_q;
  assign full_o     = full_q;
  assign brk_irq_o  = irq_q;
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          rx_dis_i,
  input  logic          rx_reset_i,
  input  logic          push_valid_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          break_i,
  input  logic          brk_clr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          ready_o,
  output logic          data_rdy_o,
  output logic          full_o,
  output logic          brk_irq_o,
  output logic [CW-1:0] count_o
);
  rxq_pkg::rxq_op_t op;
  logic [DW-1:0]    wdata;
  logic [PW-1:0]    rptr, widx;
  logic [CW-1:0]    cnt;

  rxq_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .rx_en_i, .rx_dis_i, .rx_reset_i,
    .push_valid_i, .push_data_i, .break_i, .rd_i,
    .cnt_i(cnt), .full_i(full_o), .ready_o, .op_o(op), .wdata_o(wdata)
  );

  rxq_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni, .op_i(op), .rptr_o(rptr), .widx_o(widx), .cnt_o(cnt)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni, .we_i(op.push | op.ovw), .widx_i(widx),
    .wdata_i(wdata), .rptr_i(rptr), .cnt_i(cnt), .rdata_o(rd_data_o)
  );

  rxq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i, .rst_ni, .op_i(op), .brk_clr_i, .cnt_i(cnt),
    .data_rdy_o, .full_o, .brk_irq_o
  );

  assign count_o = cnt;
endmodule

// File: rtl/rx_hold_queue_chk.sv
module rx_hold_queue_chk #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en_i,
  input logic          rx_dis_i,
  input logic          rx_reset_i,
  input logic          push_valid_i,
  input logic [DW-1:0] push_data_i,
  input logic          break_i,
  input logic          brk_clr_i,
  input logic          rd_i,
  input logic [DW-1:0] rd_data_o,
  input logic          ready_o,
  input logic          data_rdy_o,
  input logic          full_o,
  input logic          brk_irq_o,
  input logic [CW-1:0] count_o
);
  assert_full_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (count_o == CW'(DEPTH)));

  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  assert_rdy_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rdy_o == (count_o != '0));

  assert_empty_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> (rd_data_o == '0));

  assert_empty_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && count_o == '0 && !push_valid_i && !break_i && !rx_reset_i)
    |=> (count_o == '0 && !data_rdy_o));

  assert_brk_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i |=> brk_irq_o);

  assert_brk_ovw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && break_i && !rd_i && !rx_reset_i) |=> (full_o && count_o == CW'(DEPTH)));

  assert_ready_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !full_o);

  assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_i |=> (count_o == '0 && !ready_o && !full_o && !data_rdy_o));

  assert_pushpop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && ready_o && rd_i && count_o != '0 && !break_i && !rx_reset_i)
    |=> $stable(count_o));
endmodule

bind rx_hold_queue rx_hold_queue_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/rx_hold_queue_test.sv
module rx_hold_queue_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 0, rx_dis_i = 0, rx_reset_i = 0;
  logic       push_valid_i = 0, break_i = 0, brk_clr_i = 0, rd_i = 0;
  logic [7:0] push_data_i = '0;
  logic [7:0] rd_data_o;
  logic       ready_o, data_rdy_o, full_o, brk_irq_o;
  logic [2:0] count_o;

  rx_hold_queue uut (.*);

  always #4 clk_i = ~clk_i;

  int vectors = 0, errors = 0, cycles = 0;
  logic [7:0] mq [4];
  int  mc = 0;
  bit  men = 0, mirq = 0;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int head();
    return (mc == 0) ? 0 : int'(mq[0]);
  endfunction

  task automatic check_all();
    chk("R3 rd_data",  rd_data_o,  head());
    chk("R1 full",     full_o,     int'(mc == 4));
    chk("R2 data_rdy", data_rdy_o, int'(mc != 0));
    chk("R7 ready",    ready_o,    int'(men && mc != 4));
    chk("R5 brk_irq",  brk_irq_o,  int'(mirq));
    chk("R10 count",   count_o,    mc);
  endtask

  // drive one cycle at negedge, advance the model, step to next negedge
  task automatic apply(input bit en, dis, rs, pv, input logic [7:0] pd,
                       input bit bk, cl, rd);
    bit rdy;
    check_all();
    rx_en_i = en; rx_dis_i = dis; rx_reset_i = rs; push_valid_i = pv;
    push_data_i = pd; break_i = bk; brk_clr_i = cl; rd_i = rd;
    rdy = men && mc != 4;
    if (bk) mirq = 1; else if (cl) mirq = 0;
    if (rs) mc = 0;
    else begin
      if (rd && mc > 0) begin
        for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
        mc--;
      end
      if (bk) begin
        if (mc == 4) mq[3] = 8'h00;
        else begin mq[mc] = 8'h00; mc++; end
      end else if (pv && rdy) begin
        mq[mc] = pd; mc++;
      end
    end
    if (rs || dis) men = 0; else if (en) men = 1;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(); apply(0,0,0,0,8'h00,0,0,0); endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 reset count", count_o, 0);
    chk("R9 reset ready", ready_o, 0);
    chk("R4 reset data",  rd_data_o, 0);

    // R7: offer while disabled is dropped
    apply(0,0,0,1,8'hA5,0,0,0);
    chk("R7 dropped while off", count_o, 0);
    // R4: empty read
    apply(0,0,0,0,8'h00,0,0,1);
    chk("R4 empty read count", count_o, 0);
    chk("R4 empty read data",  rd_data_o, 0);
    // R9: enable and disable together -> off
    apply(1,1,0,0,8'h00,0,0,0);
    chk("R9 dis beats en", ready_o, 0);
    apply(1,0,0,0,8'h00,0,0,0);
    chk("R9 enabled", ready_o, 1);
    // fill with 11,22,33,44 then extra offer dropped
    apply(0,0,0,1,8'h11,0,0,0);
    apply(0,0,0,1,8'h22,0,0,0);
    apply(0,0,0,1,8'h33,0,0,0);
    apply(0,0,0,1,8'h44,0,0,0);
    chk("R1 full at four", full_o, 1);
    apply(0,0,0,1,8'h55,0,0,0);
    chk("R7 dropped when full", count_o, 4);
    // R6: break on full overwrites newest
    apply(0,0,0,0,8'h00,1,0,0);
    chk("R6 count stays", count_o, 4);
    chk("R5 flag set", brk_irq_o, 1);
    apply(0,0,0,0,8'h00,0,0,1);
    chk("R3 oldest first", rd_data_o, 8'h22);
    apply(0,0,0,0,8'h00,0,0,1);
    apply(0,0,0,0,8'h00,0,0,1);
    chk("R6 newest replaced", rd_data_o, 8'h00);
    // R5: set beats clear
    apply(0,0,0,0,8'h00,1,1,0);
    chk("R5 set wins", brk_irq_o, 1);
    apply(0,0,0,0,8'h00,0,1,0);
    chk("R5 cleared", brk_irq_o, 0);
    // full + break + read: plain append
    idle();
    while (mc < 4) apply(0,0,0,1,8'h60 + 8'(mc),0,0,0);
    apply(0,0,0,0,8'h00,1,0,1);
    chk("R6 read then append", count_o, 4);
    // R10: push and pop together
    apply(0,0,0,0,8'h00,0,0,1);
    apply(0,0,0,1,8'h77,0,0,1);
    chk("R10 count unchanged", count_o, 3);
    // R8: flush
    apply(0,0,1,1,8'h88,0,0,0);
    chk("R8 flushed", count_o, 0);
    chk("R8 off", ready_o, 0);
    chk("R8 brk kept", brk_irq_o, int'(mirq));

    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      apply($urandom_range(0,99) < 12, $urandom_range(0,99) < 3,
            $urandom_range(0,199) < 3, $urandom_range(0,99) < 55,
            8'($urandom), $urandom_range(0,99) < 5,
            $urandom_range(0,99) < 10, r < 40);
    end
    check_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule